// File: doc/BRIEF.md
# Sliding-Window FIR Accelerator

This unit sits beside a small processor core and takes commands from its custom-instruction port. It keeps the most recent `TAPS` samples in a shift window and a bank of `TAPS` signed coefficients. On each sample push it runs a fixed three-step sequence. First it snapshots the coefficients. Then it forms every product and their sum in one step. Finally it writes the result to a response port, where a one-cycle valid strobe marks it.

Four commands reach the unit on a 2-bit opcode: push a sample, write one coefficient, empty the window, and pick the filter mode. The unit refuses every command while a push sequence is running, and signals this on `busy`. The response also carries a flag. The flag says whether the window has been filled with real samples since the last clear or reset.

The control is a four-state machine. `ST_IDLE` moves to `ST_FETCH` on an accepted push (transition "start"). `ST_FETCH` moves to `ST_MAC` after capturing the coefficients ("fetched"). `ST_MAC` moves to `ST_WB` after registering the sum ("summed"). `ST_WB` returns to `ST_IDLE` while writing the response ("written"). Every other command is handled in `ST_IDLE` in a single edge and does not leave that state.

Top module: `fir_window_engine`

## Requirements
- R1: The window shifts on each accepted push. The new sample enters tap 0 (newest), every other sample moves one tap toward tap `TAPS-1`, and the sample at tap `TAPS-1` is dropped.
- R2: In weighted mode the response equals the sum over k of coefficient k times tap k. Tap 0 is the newest sample and samples are 16-bit signed. The sum is kept at full precision in `2*DW+clog2(TAPS)` bits, so it never wraps, even when every sample and coefficient is -32768.
- R3: A push (opcode 0, sample on `cmd_data`) is accepted at a clock edge where `cmd_valid` is high and `busy` is low. `busy` is then high for exactly the next three cycles. `rsp_valid` is high for exactly one cycle, beginning at the edge where `busy` falls.
- R4: Any command presented while `busy` is high is ignored. It changes neither the window, the coefficients nor the mode.
- R5: Coefficient write (opcode 1) stores `cmd_data` into the tap selected by `cmd_idx`. It completes in one edge, does not raise `busy`, and is used by later pushes.
- R6: Clear (opcode 2) sets every window entry to zero, resets the count of pushes, and drops `rsp_full`. It keeps the coefficients and the mode and does not raise `busy`.
- R7: `rsp_full`, updated together with each response, is 1 only when at least `TAPS` pushes have been accepted since the last clear or reset.
- R8: Mode select (opcode 3) takes `cmd_data[0]`. A value of 1 selects moving-sum mode, where every coefficient is taken as 1. A value of 0 selects weighted mode. Reset selects weighted mode.
- R9: After reset `busy`, `rsp_valid`, `rsp_full` and `rsp_data` are 0, and the window and all coefficients are zero.
- R10: With no feedback path, after `TAPS` consecutive zero samples the response is exactly zero whatever came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Opcode: 0 push, 1 coefficient write, 2 clear, 3 mode |
| cmd_idx | input | IDX_W | Tap index for coefficient write |
| cmd_data | input | DW | Sample, coefficient, or mode bit 0 |
| busy | output | 1 | Push sequence running; commands refused |
| rsp_valid | output | 1 | One-cycle strobe: new result on rsp_data |
| rsp_full | output | 1 | Result was formed from a full window |
| rsp_data | output | ACC_W | Filter result, signed |

## Verification
The assertions assume `cmd_op` is a defined value whenever `cmd_valid` is high. They also assume a command's outcome is judged only from the acceptance edge, with `busy` low there. The stimulus drives commands on falling edges and holds each for one cycle. It deliberately issues some commands during `busy` to exercise refusal. A behavioural model in the bench follows the same acceptance rule without looking at the design. It uses a sample queue and integer sums, including extreme-magnitude operands.

// File: rtl/fir_eng_pkg.sv
package fir_eng_pkg;

    typedef enum logic [1:0] {
        OP_PUSH  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_CLEAR = 2'd2,
        OP_MODE  = 2'd3
    } fir_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_MAC,
        ST_WB
    } fir_state_e;

    typedef enum logic {
        MODE_WEIGHTED = 1'b0,
        MODE_BOXCAR   = 1'b1
    } fir_mode_e;

endpackage

// File: rtl/fir_sample_window.sv
module fir_sample_window #(
    parameter int TAPS = 8,
    parameter int DW   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_en,
    input  logic                     clear_en,
    input  logic [DW-1:0]            din,
    output logic [TAPS-1:0][DW-1:0]  taps_o
);

    logic [TAPS-1:0][DW-1:0] stage_q;

    // Tap 0 holds the newest sample; the last tap ages out.
    for (genvar k = 0; k < TAPS; k++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[k] <= '0;
            end else if (clear_en) begin
                stage_q[k] <= '0;
            end else if (shift_en) begin
                if (k == 0) begin
                    stage_q[k] <= din;
                end else begin
                    stage_q[k] <= stage_q[k-1];
                end
            end
        end
    end

    assign taps_o = stage_q;

endmodule

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
    parameter int TAPS  = 8,
    parameter int DW    = 16,
    parameter int IDX_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [DW-1:0]            wr_data,
    output logic [TAPS-1:0][DW-1:0]  coef_o
);

    logic [TAPS-1:0][DW-1:0] coef_q;

    for (genvar k = 0; k < TAPS; k++) begin : g_coef
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                coef_q[k] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(k))) begin
                coef_q[k] <= wr_data;
            end
        end
    end

    assign coef_o = coef_q;

endmodule

// File: rtl/fir_mac_tree.sv
module fir_mac_tree #(
    parameter int TAPS  = 8,
    parameter int DW    = 16,
    parameter int ACC_W = 35
) (
    input  logic [TAPS-1:0][DW-1:0] samp_i,
    input  logic [TAPS-1:0][DW-1:0] coef_i,
    output logic [ACC_W-1:0]        sum_o
);

    localparam int PW = 2 * DW;

    logic [TAPS-1:0][PW-1:0] prod;

    for (genvar k = 0; k < TAPS; k++) begin : g_mul
        assign prod[k] = PW'($signed(samp_i[k]) * $signed(coef_i[k]));
    end

    always_comb begin
        sum_o = '0;
        for (int k = 0; k < TAPS; k++) begin
            sum_o = sum_o + {{(ACC_W-PW){prod[k][PW-1]}}, prod[k]};
        end
    end

endmodule

// File: rtl/fir_sequencer.sv
module fir_sequencer
    import fir_eng_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic cap_coef,
    output logic cap_sum,
    output logic wr_rsp
);

    fir_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_MAC;
            ST_MAC:   state_d = ST_WB;
            ST_WB:    state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = 1'b1;
        cap_coef = 1'b0;
        cap_sum  = 1'b0;
        wr_rsp   = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy     = 1'b0;
            ST_FETCH: cap_coef = 1'b1;
            ST_MAC:   cap_sum  = 1'b1;
            ST_WB:    wr_rsp   = 1'b1;
            default:  busy     = 1'b0;
        endcase
    end

endmodule

// File: rtl/fir_window_engine.sv
module fir_window_engine
    import fir_eng_pkg::*;
#(
    parameter int TAPS  = 8,
    parameter int DW    = 16,
    parameter int IDX_W = (TAPS > 1) ? $clog2(TAPS) : 1,
    parameter int ACC_W = 2 * DW + ((TAPS > 1) ? $clog2(TAPS) : 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic [DW-1:0]    cmd_data,
    output logic             busy,
    output logic             rsp_valid,
    output logic             rsp_full,
    output logic [ACC_W-1:0] rsp_data
);

    localparam int CNT_W = $clog2(TAPS + 1);

    fir_op_e   op;
    fir_mode_e mode_q;
    logic      accept, do_push, do_load, do_clear, do_mode;
    logic      cap_coef, cap_sum, wr_rsp;

    logic [TAPS-1:0][DW-1:0] win_taps, coef_taps, coef_snap_q;
    logic [ACC_W-1:0]        sum_w, sum_q;
    logic [CNT_W-1:0]        fill_q;

    assign op       = fir_op_e'(cmd_op);
    assign accept   = cmd_valid && !busy;
    assign do_push  = accept && (op == OP_PUSH);
    assign do_load  = accept && (op == OP_LOAD);
    assign do_clear = accept && (op == OP_CLEAR);
    assign do_mode  = accept && (op == OP_MODE);

    fir_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (do_push),
        .busy     (busy),
        .cap_coef (cap_coef),
        .cap_sum  (cap_sum),
        .wr_rsp   (wr_rsp)
    );

    fir_sample_window #(.TAPS(TAPS), .DW(DW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (do_push),
        .clear_en (do_clear),
        .din      (cmd_data),
        .taps_o   (win_taps)
    );

    fir_coef_bank #(.TAPS(TAPS), .DW(DW), .IDX_W(IDX_W)) u_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (do_load),
        .wr_idx  (cmd_idx),
        .wr_data (cmd_data),
        .coef_o  (coef_taps)
    );

    fir_mac_tree #(.TAPS(TAPS), .DW(DW), .ACC_W(ACC_W)) u_mac (
        .samp_i (win_taps),
        .coef_i (coef_snap_q),
        .sum_o  (sum_w)
    );

    // Mode register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_WEIGHTED;
        end else if (do_mode) begin
            mode_q <= cmd_data[0] ? MODE_BOXCAR : MODE_WEIGHTED;
        end
    end

    // Fill counter, saturating at TAPS
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (do_clear) begin
            fill_q <= '0;
        end else if (do_push && (fill_q < CNT_W'(TAPS))) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    // Step 1: coefficient fetch; moving-sum mode substitutes unity weights
    for (genvar k = 0; k < TAPS; k++) begin : g_snap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                coef_snap_q[k] <= '0;
            end else if (cap_coef) begin
                coef_snap_q[k] <= (mode_q == MODE_BOXCAR) ? DW'(1) : coef_taps[k];
            end
        end
    end

    // Step 2: multiply-sum register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (cap_sum) begin
            sum_q <= sum_w;
        end
    end

    // Step 3: writeback to response port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_full  <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= wr_rsp;
            if (wr_rsp) begin
                rsp_data <= sum_q;
                rsp_full <= (fill_q == CNT_W'(TAPS));
            end else if (do_clear) begin
                rsp_full <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fir_window_engine_chk.sv
module fir_window_engine_chk #(
    parameter int IDX_W = 3,
    parameter int DW    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic [IDX_W-1:0] cmd_idx,
    input logic [DW-1:0]    cmd_data,
    input logic             busy,
    input logic             rsp_valid,
    input logic             rsp_full
);

    logic take;
    assign take = cmd_valid && !busy;

    p_push_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == 2'd0) |=> busy ##1 busy ##1 busy ##1 (!busy && rsp_valid));

    p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_quiet_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rsp_valid);

    p_single_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op != 2'd0) |=> (!busy && !rsp_valid));

    p_clear_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == 2'd2) |=> !rsp_full);

    p_full_with_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_full) |-> rsp_valid);

    p_rsp_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $fell(busy));

endmodule

bind fir_window_engine fir_window_engine_chk #(.IDX_W(IDX_W), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_idx   (cmd_idx),
    .cmd_data  (cmd_data),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_full  (rsp_full)
);

// File: tb/fir_window_engine_test.sv
`timescale 1ns/1ps
module fir_window_engine_test;

    localparam int TAPS  = 8;
    localparam int DW    = 16;
    localparam int IDX_W = 3;
    localparam int ACC_W = 2 * DW + 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_op = 2'd0;
    logic [IDX_W-1:0] cmd_idx = '0;
    logic [DW-1:0]    cmd_data = '0;
    logic             busy, rsp_valid, rsp_full;
    logic [ACC_W-1:0] rsp_data;

    always #2.5 clk = ~clk;

    fir_window_engine #(.TAPS(TAPS), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_idx(cmd_idx), .cmd_data(cmd_data), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_full(rsp_full), .rsp_data(rsp_data)
    );

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string tag   = "R9";

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    longint m_win[$];
    longint m_coef[TAPS];
    bit     m_boxcar;
    int     m_fill;
    int     m_cnt;
    bit     m_rv;
    bit     m_rfull;
    longint m_rdata;
    longint m_pend;
    bit     m_pend_full;

    task automatic model_reset();
        m_win.delete();
        for (int k = 0; k < TAPS; k++) begin
            m_win.push_back(0);
            m_coef[k] = 0;
        end
        m_boxcar = 0; m_fill = 0; m_cnt = 0;
        m_rv = 0; m_rfull = 0; m_rdata = 0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit was_idle;
            was_idle = (m_cnt == 0);
            m_rv = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_rv = 1; m_rdata = m_pend; m_rfull = m_pend_full;
                end
            end else if (was_idle && cmd_valid) begin
                case (cmd_op)
                    2'd0: begin
                        longint s;
                        m_win.push_front(longint'($signed(cmd_data)));
                        void'(m_win.pop_back());
                        if (m_fill < TAPS) m_fill++;
                        s = 0;
                        for (int k = 0; k < TAPS; k++)
                            s += m_win[k] * (m_boxcar ? 64'sd1 : m_coef[k]);
                        m_pend = s; m_pend_full = (m_fill >= TAPS); m_cnt = 3;
                    end
                    2'd1: m_coef[cmd_idx] = longint'($signed(cmd_data));
                    2'd2: begin
                        for (int k = 0; k < TAPS; k++) m_win[k] = 0;
                        m_fill = 0; m_rfull = 0;
                    end
                    default: m_boxcar = cmd_data[0];
                endcase
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(busy == (m_cnt > 0), {tag, "/R3 busy"}, busy, m_cnt > 0);
            check(rsp_valid == m_rv, {tag, "/R3 rsp_valid"}, rsp_valid, m_rv);
            check(rsp_full == m_rfull, {tag, "/R7 rsp_full"}, rsp_full, m_rfull);
            check(longint'($signed(rsp_data)) == m_rdata, {tag, "/R2 rsp_data"},
                  longint'($signed(rsp_data)), m_rdata);
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input logic [1:0] op, input int idx, input int data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = IDX_W'(idx); cmd_data = DW'(data);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic push_wait(input int data);
        send(2'd0, 0, data);
        repeat (3) @(negedge clk);
    endtask

    logic [31:0] lcg = 32'h1234_5678;
    function automatic int next_rand();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return int'($signed(lcg[23:8]));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finish");
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(busy == 0, "R9 busy", busy, 0);
        check(rsp_valid == 0, "R9 rsp_valid", rsp_valid, 0);
        check(rsp_full == 0, "R9 rsp_full", rsp_full, 0);
        check(rsp_data == 0, "R9 rsp_data", longint'(rsp_data), 0);

        // R5 coefficient writes, R1 impulse walks through taps
        tag = "R5";
        for (int k = 0; k < TAPS; k++) send(2'd1, k, (k + 1) * 10 - 35);
        tag = "R1";
        push_wait(1000);
        for (int k = 1; k < TAPS + 2; k++) push_wait(0);

        // R2 mixed patterns and extreme operands
        tag = "R2";
        for (int i = 0; i < 40; i++) push_wait(next_rand());
        for (int k = 0; k < TAPS; k++) send(2'd1, k, -32768);
        for (int i = 0; i < TAPS + 2; i++) push_wait(-32768);
        check(longint'($signed(rsp_data)) == longint'(TAPS) * 32768 * 32768,
              "R2 extreme", longint'($signed(rsp_data)), longint'(TAPS) * 32768 * 32768);
        for (int k = 0; k < TAPS; k++) send(2'd1, k, next_rand());

        // R4 commands presented during busy are ignored
        tag = "R4";
        for (int i = 0; i < 6; i++) begin
            send(2'd0, 0, next_rand());
            send(2'd1, 0, 777);
            send(2'd3, 0, 1);
            send(2'd0, 0, 5);
            @(negedge clk);
        end
        push_wait(123);

        // R6 clear, R7 fill flag restarts
        tag = "R6";
        send(2'd2, 0, 0);
        @(negedge clk);
        check(rsp_full == 0, "R6 clear drops full", rsp_full, 0);
        tag = "R7";
        for (int i = 0; i < TAPS + 1; i++) push_wait(next_rand());

        // R8 moving-sum mode and back
        tag = "R8";
        send(2'd3, 0, 1);
        for (int i = 0; i < TAPS + 3; i++) push_wait(next_rand());
        send(2'd3, 0, 0);
        for (int i = 0; i < 4; i++) push_wait(next_rand());

        // R10 zero flush
        tag = "R10";
        for (int i = 0; i < TAPS; i++) push_wait(0);
        check(rsp_data == 0, "R10 flushed", longint'($signed(rsp_data)), 0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule